// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer

This block is a watchdog counter that runs on the system clock. If software does not restart it in time, it requests a non-maskable interrupt. A 16-bit mode register is written through a plain strobe-and-data port and can always be read back. The top bit of that register is an active-low run control: while it is 1 the counter is held at zero, and while it is 0 the counter advances on every clock.

Software keeps the interrupt away by writing the run bit to 1 and then back to 0 on consecutive writes. This restarts the count from zero. A 2-bit period field picks the interval, with a non-monotonic code: 00 selects 2^16 clocks, 01 selects 2^4, 10 selects 2^12 and 11 selects 2^14. At 12 MHz the longest setting is about 5.46 ms.

The register resets to all zeros, so the watchdog runs from reset with the longest interval. The remaining 13 register bits are plain storage for the neighbouring mode controls.

Top module: `selper_watchdog`

## Requirements
- R1: After reset the mode register reads 0x0000 and the counter runs with the 2^16 interval, so the first interrupt pulse appears on the 65536th rising edge after reset is released.
- R2: While bit 15 of the mode register is 1, the counter is held at zero and no interrupt pulse is produced, however long the bit stays set.
- R3: When a write clears bit 15, the counter starts from zero, and the first pulse appears on the L-th rising edge after the edge that stored the write, where L is the selected interval.
- R4: Bits 14:13 select the interval L: code 00 gives 65536 clocks, 01 gives 16, 10 gives 4096 and 11 gives 16384.
- R5: Each interrupt pulse is high for exactly one clock. The counter then wraps to zero and keeps running, so pulses repeat every L clocks while bit 15 stays 0.
- R6: Writing bit 15 to 1 and then to 0 on two consecutive register writes restarts the interval. The next pulse comes L edges after the second write, and the pulse the earlier count would have produced does not appear.
- R7: If the period field is changed while the counter is running, the new interval applies from the next edge. A count already at or past the new limit produces a pulse on the very next edge.
- R8: A write stores all 16 bits on the next rising edge, and the read data port returns the stored value, including bits 12:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Mode register write strobe |
| reg_wdata | input | 16 | Mode register write data |
| reg_rdata | output | 16 | Mode register contents |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The hardest case to reach from the ports is a change to a shorter interval while the count is already past the new limit. The stimulus sets the 4096-clock interval, lets the counter run about a hundred clocks, and then writes the 16-clock code with the run bit still 0. It expects a pulse on the very next edge and a second pulse 16 edges later. The clear sequence is placed so that the pulse the old count would have produced falls inside the expected window. Any pulse that was not predicted is flagged as a mismatch.

// File: rtl/selper_wdt_pkg.sv
package selper_wdt_pkg;

   localparam int MODE_W   = 16;
   localparam int HALT_POS = 15;
   localparam int SEL_LO   = 13;
   localparam int SEL_W    = 2;

   typedef enum logic [SEL_W-1:0] {
      PER_LONG = 2'b00,
      PER_TINY = 2'b01,
      PER_MID  = 2'b10,
      PER_BIG  = 2'b11
   } per_sel_e;

endpackage

// File: rtl/selper_mode_reg.sv
module selper_mode_reg
   import selper_wdt_pkg::*;
#(
   parameter int W        = MODE_W,
   parameter int HALT_AT  = HALT_POS,
   parameter int SEL_AT   = SEL_LO
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         halt,
   output per_sel_e     sel
);

   if (HALT_AT >= W) begin : g_bad_halt
      $error("halt bit position outside the register");
   end
   if (SEL_AT + SEL_W > W) begin : g_bad_sel
      $error("period field outside the register");
   end
   if (HALT_AT >= SEL_AT && HALT_AT < SEL_AT + SEL_W) begin : g_overlap
      $error("halt bit overlaps the period field");
   end

   logic [W-1:0] mode_q;

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q[b] <= 1'b0;
         end else if (we) begin
            mode_q[b] <= wdata[b];
         end
      end
   end

   assign rdata = mode_q;
   assign halt  = mode_q[HALT_AT];
   assign sel   = per_sel_e'(mode_q[SEL_AT +: SEL_W]);

   // R8
   rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata == $past(wdata));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(rdata));

endmodule

// File: rtl/selper_limit_dec.sv
module selper_limit_dec
   import selper_wdt_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int EXP_LONG = 16,
   parameter int EXP_TINY = 4,
   parameter int EXP_MID  = 12,
   parameter int EXP_BIG  = 14
) (
   input  per_sel_e         sel,
   output logic [CNT_W-1:0] term
);

   localparam int NCODE = 1 << SEL_W;
   localparam int EXPS [NCODE] = '{EXP_LONG, EXP_TINY, EXP_MID, EXP_BIG};

   logic [CNT_W-1:0] tab [NCODE];

   for (genvar i = 0; i < NCODE; i++) begin : g_code
      if (EXPS[i] < 1 || EXPS[i] > CNT_W) begin : g_bad_exp
         $error("interval exponent must lie in 1..CNT_W");
      end
      assign tab[i] = CNT_W'((64'(1) << EXPS[i]) - 64'(1));
   end

   always_comb begin
      term = tab[sel];
   end

   // R4
   always_comb begin
      if (!$isunknown(sel)) begin
         term_pow2_chk: assert ($countones({1'b0, term} + (CNT_W+1)'(1)) == 1);
      end
   end

endmodule

// File: rtl/selper_wdt_count.sv
module selper_wdt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic [CNT_W-1:0] term,
   output logic             nmi,
   output logic [CNT_W-1:0] cnt
);

   if (CNT_W < 2) begin : g_bad_w
      $error("counter width must be at least 2");
   end

   logic hit;
   assign hit = (cnt >= term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         nmi <= 1'b0;
      end else if (halt) begin
         cnt <= '0;
         nmi <= 1'b0;
      end else if (hit) begin
         cnt <= '0;
         nmi <= 1'b1;
      end else begin
         cnt <= cnt + CNT_W'(1);
         nmi <= 1'b0;
      end
   end

   // R2
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (cnt == '0) && !nmi);

   // R5
   nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |=> !nmi);

   // R5
   nmi_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |-> cnt == '0);

   // R7
   over_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt && cnt >= term) |=> nmi);

endmodule

// File: rtl/selper_watchdog.sv
module selper_watchdog
   import selper_wdt_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int EXP_LONG = 16,
   parameter int EXP_TINY = 4,
   parameter int EXP_MID  = 12,
   parameter int EXP_BIG  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [MODE_W-1:0] reg_wdata,
   output logic [MODE_W-1:0] reg_rdata,
   output logic              nmi_req
);

   logic             halt;
   per_sel_e         sel;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt;

   selper_mode_reg #(
      .W       (MODE_W),
      .HALT_AT (HALT_POS),
      .SEL_AT  (SEL_LO)
   ) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .halt  (halt),
      .sel   (sel)
   );

   selper_limit_dec #(
      .CNT_W    (CNT_W),
      .EXP_LONG (EXP_LONG),
      .EXP_TINY (EXP_TINY),
      .EXP_MID  (EXP_MID),
      .EXP_BIG  (EXP_BIG)
   ) u_dec (
      .sel  (sel),
      .term (term)
   );

   selper_wdt_count #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .halt  (halt),
      .term  (term),
      .nmi   (nmi_req),
      .cnt   (cnt)
   );

   // R3
   start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt) |-> cnt == '0);

endmodule

// File: tb/selper_watchdog_test.sv
`timescale 1ns/1ps
module selper_watchdog_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        nmi_req;

   int    edge_n = 0;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;
   int    exp_q [$];
   string tag_q [$];

   always #2 clk = ~clk;

   always @(posedge clk) edge_n <= edge_n + 1;

   selper_watchdog uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .nmi_req   (nmi_req)
   );

   // monitor: every pulse must match the head of the queue
   always @(negedge clk) begin
      if (rst_n && nmi_req === 1'b1) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected pulse: actual edge %0d expected none", edge_n);
         end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e != edge_n) begin
               n_bad++;
               $display("FAIL %s pulse edge: actual %0d expected %0d", t, edge_n, e);
            end
         end
      end
   end

   function automatic int per_len(input int code);
      case (code)
         0: return 65536;
         1: return 16;
         2: return 4096;
         default: return 16384;
      endcase
   endfunction

   task automatic push(input int e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   // called at a negedge, returns at the next negedge
   task automatic wr(input logic [15:0] d, output int at);
      reg_we    = 1'b1;
      reg_wdata = d;
      at        = edge_n + 1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_rd(input logic [15:0] e, input string t);
      n_cmp++;
      if (reg_rdata !== e) begin
         n_bad++;
         $display("FAIL %s readback: actual %h expected %h", t, reg_rdata, e);
      end
   endtask

   task automatic drained(input string t);
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL %s missing pulse: actual none expected edge %0d", t, exp_q[0]);
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      int w;
      int w2;
      int f;
      idle(3);
      rst_n = 1'b1;
      f = edge_n + 1;
      // R1: reset value and default long interval
      chk_rd(16'h0000, "R1");
      push(f + 65535, "R1");
      idle(65540);
      wr(16'h8000, w);
      chk_rd(16'h8000, "R8");
      drained("R1");

      // R2: halted counter stays silent with the shortest interval chosen
      wr(16'hA000, w);
      idle(80);
      drained("R2");
      chk_rd(16'hA000, "R2");

      // R3 R4 R5: every code, two pulses each
      for (int c = 1; c < 4; c++) begin
         logic [15:0] off;
         int          len;
         off = {1'b1, 2'(c), 13'h0};
         len = per_len(c);
         wr(off, w);
         wr({1'b0, 2'(c), 13'h0}, w);
         push(w + len, "R3");
         push(w + 2 * len, "R5");
         idle(2 * len + 3);
         wr(off, w);
         drained("R4");
      end

      // R6: clear sequence before the pulse is due
      wr(16'hA000, w);
      wr(16'h2000, w);
      idle(9);
      wr(16'hA000, w);
      wr(16'h2000, w2);
      push(w2 + 16, "R6");
      push(w2 + 32, "R6");
      idle(35);
      wr(16'hA000, w);
      drained("R6");

      // R7: switch from 4096 to 16 while the count is about 100
      wr(16'hC000, w);
      wr(16'h4000, w);
      idle(100);
      wr(16'h2000, w2);
      push(w2 + 1, "R7");
      push(w2 + 17, "R7");
      idle(20);
      wr(16'hA000, w);
      drained("R7");

      // R8: low bits are plain storage
      wr(16'h9E5A, w);
      chk_rd(16'h9E5A, "R8");
      wr(16'hE1A5, w);
      chk_rd(16'hE1A5, "R8");
      idle(40);
      drained("R8");

      finish_run();
   end

   initial begin
      #(4 * 190000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule